// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

This block places a fixed list of internal peripheral signals onto an eight-pin general-purpose port. Six peripheral groups are ranked. Every group that is enabled takes the lowest-numbered pins that are still free, working down the ranking. When a higher group is switched on, every group below it moves up to later pins. Pins can be withheld from the scan by a skip mask or by marking them analog. Pins that no signal claims act as plain GPIO and are driven from the port latch.

For each pin the block registers four outputs: the drive value, the output enable, the push-pull flag and the weak pull-up enable. The pad level is returned to each routed peripheral input. An input that is not routed reads 1. The raw pad levels always go back to the latch read path, whatever the configuration is.

Top module: `pin_xbar_top`

## Requirements
- R1: Signal slots are ranked 0..12 in scan order. Group-enable bit 0 owns slots 0-1, bit 1 owns slots 2-3, bit 2 owns slots 4-5, bit 3 owns slot 6, bit 4 owns slots 7-10 and bit 5 owns slots 11-12. The slots of enabled groups are taken in rising order, and each one is given the lowest-numbered pin that is still unclaimed.
- R2: A pin whose bit is set in `skip_msk` or `ana_msk` is never given to a slot. The scan moves on to the next pin that is not blocked.
- R3: An enabled slot that finds no free pin stays unconnected. Its `periph_in` bit reads 1.
- R4: A claimed pin registers `pad_o` equal to its slot's `periph_out` bit and `pad_pp` equal to its `pp_msk` bit (1 = push-pull). Its `pad_oe` follows the slot's `periph_oe` bit, subject to R6.
- R5: An unclaimed pin that is not analog is GPIO. It registers `pad_o` equal to its `port_latch` bit and requests output enable.
- R6: When `pp_msk` is 0 (open-drain), `pad_oe` is 0 whenever the value to drive is 1. This applies to claimed and GPIO pins alike.
- R7: An analog pin (`ana_msk` bit 1) always registers `pad_oe` = 0 and `pad_pu` = 0.
- R8: While `xbar_en` is 0, no slot is claimed, every `pad_oe` is 0 and every `periph_in` bit is 1.
- R9: `port_rd` equals `pad_i` at all times, combinationally.
- R10: `pad_pu` of a pin is 1 exactly when `pu_dis` is 0 and the pin is not analog.
- R11: `pad_o`, `pad_oe`, `pad_pp` and `pad_pu` are registered. They show the inputs from the previous rising clock edge and are all 0 while `rst_n` is low.
- R12: A routed slot's `periph_in` bit equals the `pad_i` bit of its assigned pin, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pad output registers |
| rst_n | input | 1 | Active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| grp_en | input | 6 | Per-group enable, bit 0 highest rank |
| skip_msk | input | 8 | Pins excluded from the scan |
| ana_msk | input | 8 | Pins in analog input mode |
| pp_msk | input | 8 | Output mode per pin, 1 = push-pull |
| pu_dis | input | 1 | Global weak pull-up disable |
| port_latch | input | 8 | GPIO drive values |
| periph_out | input | 13 | Peripheral drive value per slot |
| periph_oe | input | 13 | Peripheral output request per slot |
| pad_i | input | 8 | Pad input levels |
| periph_in | output | 13 | Pad level returned to each slot |
| port_rd | output | 8 | Latch read path of pad levels |
| pad_o | output | 8 | Registered drive value |
| pad_oe | output | 8 | Registered output enable |
| pad_pp | output | 8 | Registered push-pull flag |
| pad_pu | output | 8 | Registered weak pull-up enable |

## Verification
A fault in the pin scan shows up as a slot appearing on the wrong pin. It can be seen at once on `periph_in`, and one clock later on `pad_o` and `pad_oe` of both the pin that should have been claimed and the pin that was claimed instead. A fault in the mode logic shows up one clock after the input change, as a pad driven high while in open-drain mode or an analog pad driven at all. The bench draws random enable, skip and analog combinations. It also includes the full-overflow and crossbar-off cases, so that shifted assignments and unconnected slots are both exercised.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NGRP  = 6;
  localparam int GRP_W = $clog2(NGRP);

  // pins taken by each group, highest rank first
  function automatic int grp_width(int g);
    case (g)
      0: return 2;
      1: return 2;
      2: return 2;
      3: return 1;
      4: return 4;
      default: return 2;
    endcase
  endfunction

  // first slot owned by group g
  function automatic int grp_base(int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += grp_width(k);
    return acc;
  endfunction

  localparam int NSIG   = grp_base(NGRP);
  localparam int SLOT_W = $clog2(NSIG);

  // group that owns slot s
  function automatic logic [GRP_W-1:0] slot_grp(int s);
    logic [GRP_W-1:0] r;
    r = '0;
    for (int g = 0; g < NGRP; g++)
      if (s >= grp_base(g) && s < grp_base(g) + grp_width(g)) r = GRP_W'(g);
    return r;
  endfunction
endpackage

// File: rtl/xbar_route.sv
module xbar_route import xbar_pkg::*; #(
  parameter int NPIN  = 8,
  localparam int PIN_W = $clog2(NPIN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xbar_en,
  input  logic [NGRP-1:0]              grp_en,
  input  logic [NPIN-1:0]              blocked,
  output logic [NPIN-1:0]              pin_hit,
  output logic [NPIN-1:0][SLOT_W-1:0]  pin_slot,
  output logic [NSIG-1:0]              sig_hit,
  output logic [NSIG-1:0][PIN_W-1:0]   sig_pin
);
  logic [NSIG-1:0] slot_en;
  logic [NPIN-1:0] taken;
  logic            found;

  always_comb begin
    for (int s = 0; s < NSIG; s++) slot_en[s] = xbar_en & grp_en[slot_grp(s)];
  end

  // ranked scan: each enabled slot takes the lowest free pin
  always_comb begin
    taken    = '0;
    pin_hit  = '0;
    pin_slot = '0;
    sig_hit  = '0;
    sig_pin  = '0;
    found    = 1'b0;
    for (int s = 0; s < NSIG; s++) begin
      found = 1'b0;
      if (slot_en[s]) begin
        for (int p = 0; p < NPIN; p++) begin
          if (!found && !blocked[p] && !taken[p]) begin
            found       = 1'b1;
            taken[p]    = 1'b1;
            pin_hit[p]  = 1'b1;
            pin_slot[p] = SLOT_W'(s);
            sig_hit[s]  = 1'b1;
            sig_pin[s]  = PIN_W'(p);
          end
        end
      end
    end
  end

  AST_BLOCKED_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_hit & blocked) == '0);  // R2
  AST_STARVED_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_en & ~sig_hit)) |-> ((pin_hit | blocked) == '1));  // R3
  AST_OFF_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |-> (sig_hit == '0));  // R8
endmodule

// File: rtl/xbar_pin_cell.sv
module xbar_pin_cell import xbar_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xbar_en,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [NSIG-1:0]   periph_out,
  input  logic [NSIG-1:0]   periph_oe,
  input  logic              latch_bit,
  input  logic              pp,
  input  logic              analog,
  input  logic              pu_dis,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              pad_pp,
  output logic              pad_pu
);
  logic val_d, src_oe, oe_d, pu_d;

  always_comb begin
    val_d  = (hit && slot < NSIG) ? periph_out[slot] : latch_bit;
    src_oe = (hit && slot < NSIG) ? periph_oe[slot] : 1'b1;
    if (!xbar_en || analog) src_oe = 1'b0;
    oe_d = src_oe & (pp | ~val_d);
    pu_d = ~pu_dis & ~analog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
      pad_pp <= 1'b0;
      pad_pu <= 1'b0;
    end else begin
      pad_o  <= val_d;
      pad_oe <= oe_d;
      pad_pp <= pp;
      pad_pu <= pu_d;
    end
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && !pad_pp) |-> !pad_o);  // R6
  AST_ANALOG_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    analog |=> (!pad_oe && !pad_pu));  // R7
endmodule

// File: rtl/xbar_in_return.sv
module xbar_in_return import xbar_pkg::*; #(
  parameter int NPIN  = 8,
  localparam int PIN_W = $clog2(NPIN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSIG-1:0]            sig_hit,
  input  logic [NSIG-1:0][PIN_W-1:0] sig_pin,
  input  logic [NPIN-1:0]            pad_i,
  output logic [NSIG-1:0]            periph_in
);
  for (genvar s = 0; s < NSIG; s++) begin : g_ret
    assign periph_in[s] = sig_hit[s] ? pad_i[sig_pin[s]] : 1'b1;

    AST_UNROUTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_hit[s] |-> periph_in[s]);  // R3
  end
endmodule

// File: rtl/pin_xbar_top.sv
module pin_xbar_top import xbar_pkg::*; #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xbar_en,
  input  logic [NGRP-1:0] grp_en,
  input  logic [NPIN-1:0] skip_msk,
  input  logic [NPIN-1:0] ana_msk,
  input  logic [NPIN-1:0] pp_msk,
  input  logic            pu_dis,
  input  logic [NPIN-1:0] port_latch,
  input  logic [NSIG-1:0] periph_out,
  input  logic [NSIG-1:0] periph_oe,
  input  logic [NPIN-1:0] pad_i,
  output logic [NSIG-1:0] periph_in,
  output logic [NPIN-1:0] port_rd,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pp,
  output logic [NPIN-1:0] pad_pu
);
  localparam int PIN_W = $clog2(NPIN);

  logic [NPIN-1:0]             blocked;
  logic [NPIN-1:0]             pin_hit;
  logic [NPIN-1:0][SLOT_W-1:0] pin_slot;
  logic [NSIG-1:0]             sig_hit;
  logic [NSIG-1:0][PIN_W-1:0]  sig_pin;

  assign blocked = skip_msk | ana_msk;
  assign port_rd = pad_i;

  xbar_route #(.NPIN(NPIN)) i_route (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
    .blocked(blocked), .pin_hit(pin_hit), .pin_slot(pin_slot),
    .sig_hit(sig_hit), .sig_pin(sig_pin)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    xbar_pin_cell i_cell (
      .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en),
      .hit(pin_hit[p]), .slot(pin_slot[p]),
      .periph_out(periph_out), .periph_oe(periph_oe),
      .latch_bit(port_latch[p]), .pp(pp_msk[p]), .analog(ana_msk[p]),
      .pu_dis(pu_dis),
      .pad_o(pad_o[p]), .pad_oe(pad_oe[p]), .pad_pp(pad_pp[p]), .pad_pu(pad_pu[p])
    );
  end

  xbar_in_return #(.NPIN(NPIN)) i_ret (
    .clk(clk), .rst_n(rst_n), .sig_hit(sig_hit), .sig_pin(sig_pin),
    .pad_i(pad_i), .periph_in(periph_in)
  );

  AST_OFF_ALL_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |=> (pad_oe == '0));  // R8
  AST_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd == pad_i);  // R9
endmodule

// File: tb/test_pin_xbar_top.sv
`timescale 1ns/1ps
module test_pin_xbar_top;
  localparam int NP = 8;
  localparam int NS = 13;
  localparam int NG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          xbar_en, pu_dis;
  logic [NG-1:0] grp_en;
  logic [NP-1:0] skip_msk, ana_msk, pp_msk, port_latch, pad_i;
  logic [NS-1:0] periph_out, periph_oe;
  logic [NS-1:0] periph_in;
  logic [NP-1:0] port_rd, pad_o, pad_oe, pad_pp, pad_pu;

  pin_xbar_top i_pin_xbar_top (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
    .skip_msk(skip_msk), .ana_msk(ana_msk), .pp_msk(pp_msk), .pu_dis(pu_dis),
    .port_latch(port_latch), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_i(pad_i), .periph_in(periph_in), .port_rd(port_rd),
    .pad_o(pad_o), .pad_oe(pad_oe), .pad_pp(pad_pp), .pad_pu(pad_pu)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int slot_of_pin[NP];
  int pin_of_slot[NS];

  task automatic chk(string req, string what, int idx, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s[%0d] actual=%b expected=%b", req, what, idx, act, exp);
    end
  endtask

  // reference: queue of free pins, popped by groups in rank order
  task automatic build_map();
    int freeq[$];
    int s, w;
    for (int p = 0; p < NP; p++) slot_of_pin[p] = -1;
    for (int k = 0; k < NS; k++) pin_of_slot[k] = -1;
    if (!xbar_en) return;
    for (int p = 0; p < NP; p++) if (!skip_msk[p] && !ana_msk[p]) freeq.push_back(p);
    s = 0;
    for (int g = 0; g < NG; g++) begin
      w = (g == 3) ? 1 : (g == 4) ? 4 : 2;
      for (int k = 0; k < w; k++) begin
        if (grp_en[g] && freeq.size() > 0) begin
          pin_of_slot[s] = freeq.pop_front();
          slot_of_pin[pin_of_slot[s]] = s;
        end
        s++;
      end
    end
  endtask

  task automatic check_comb();
    build_map();
    for (int p = 0; p < NP; p++) chk("R9", "port_rd", p, port_rd[p], pad_i[p]);
    for (int s = 0; s < NS; s++) begin
      if (!xbar_en)
        chk("R8", "periph_in", s, periph_in[s], 1'b1);
      else if (pin_of_slot[s] < 0)
        chk("R3", "periph_in", s, periph_in[s], 1'b1);
      else if ((skip_msk | ana_msk) != '0)
        chk("R2", "periph_in", s, periph_in[s], pad_i[pin_of_slot[s]]);
      else
        chk("R1/R12", "periph_in", s, periph_in[s], pad_i[pin_of_slot[s]]);
    end
  endtask

  // inputs unchanged since last posedge: registered outputs must match them
  task automatic check_regs();
    logic v, so, oe;
    build_map();
    for (int p = 0; p < NP; p++) begin
      v  = (slot_of_pin[p] >= 0) ? periph_out[slot_of_pin[p]] : port_latch[p];
      so = (slot_of_pin[p] >= 0) ? periph_oe[slot_of_pin[p]] : 1'b1;
      if (!xbar_en || ana_msk[p]) so = 1'b0;
      oe = so && (pp_msk[p] || !v);
      chk(slot_of_pin[p] >= 0 ? "R4" : "R5", "pad_o", p, pad_o[p], v);
      chk("R4", "pad_pp", p, pad_pp[p], pp_msk[p]);
      chk("R10", "pad_pu", p, pad_pu[p], !pu_dis && !ana_msk[p]);
      if (!xbar_en)                    chk("R8", "pad_oe", p, pad_oe[p], 1'b0);
      else if (ana_msk[p])             chk("R7", "pad_oe", p, pad_oe[p], 1'b0);
      else if (!pp_msk[p] && v)        chk("R6", "pad_oe", p, pad_oe[p], 1'b0);
      else if (slot_of_pin[p] >= 0)    chk("R4", "pad_oe", p, pad_oe[p], oe);
      else                             chk("R5", "pad_oe", p, pad_oe[p], oe);
    end
  endtask

  task automatic drive(int it);
    xbar_en    = ($urandom_range(0, 7) != 0);
    grp_en     = NG'($urandom);
    skip_msk   = ($urandom_range(0, 1) == 0) ? '0 : NP'($urandom & $urandom);
    ana_msk    = ($urandom_range(0, 2) == 0) ? NP'($urandom & $urandom) : '0;
    pp_msk     = NP'($urandom);
    pu_dis     = $urandom_range(0, 1) == 1;
    port_latch = NP'($urandom);
    periph_out = NS'($urandom);
    periph_oe  = NS'($urandom);
    pad_i      = NP'($urandom);
    case (it)
      0: begin xbar_en = 1; grp_en = '1; skip_msk = '0; ana_msk = '0; end  // overflow
      1: begin xbar_en = 0; end
      2: begin xbar_en = 1; ana_msk = '1; end
      3: begin xbar_en = 1; grp_en = 6'b110000; skip_msk = 8'b0000_0101; ana_msk = '0; end
      4: begin xbar_en = 1; grp_en = 6'b000001; skip_msk = 8'b0000_0001; ana_msk = 8'b0000_0010; end
      5: begin xbar_en = 1; grp_en = '1; skip_msk = 8'hF0; ana_msk = '0; pp_msk = '0; end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(0);
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int p = 0; p < NP; p++) begin
      chk("R11", "pad_o", p, pad_o[p], 1'b0);
      chk("R11", "pad_oe", p, pad_oe[p], 1'b0);
      chk("R11", "pad_pp", p, pad_pp[p], 1'b0);
      chk("R11", "pad_pu", p, pad_pu[p], 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int it = 0; it < 3000; it++) begin
      check_regs();
      drive(it);
      #1;
      check_comb();
      @(negedge clk);
    end
    check_regs();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule